// File: doc/BRIEF.md
# Binary XNOR-Popcount Threshold Processing Element

This block is one processing element of a binarized convolution engine. Every cycle on which `in_valid` is high it takes a word of binary input activations and an equally wide word of binary weights, one bit per input channel. It treats each bit position where the two agree as a +1 product, forms the bitwise XNOR, and counts the ones with a pipelined adder tree.

The element works through its output channels one after another. For each output channel it sums the counts of `SIC` consecutive input slices. It then produces a one-bit output activation by comparing that sum with an integer threshold taken from a small per-output-channel buffer. This single integer compare stands in for activation, normalization and sign binarization; no floating-point arithmetic is involved. Each buffer entry also carries an invert bit, which reverses the comparison for channels whose folded scale factor is negative.

The thresholds are written through a plain address/data/write-enable port before inference starts. The slice position and the output-channel index come from internal counters that advance on each accepted input word. Output channels are served in order 0 to `SOC-1` and then start again at 0.

Top module: `bnn_xnor_pe`

## Requirements
- R1: During and after a synchronous active-high reset, `out_valid`, `out_act` and `out_ch` are 0, and the next accepted word is slice 0 of output channel 0.
- R2: The partial count of one input word is the number of bit positions where `in_act` and `in_wgt` hold the same value (XNOR then population count), over all `PIC` bits.
- R3: The running sum is cleared at slice 0 of every output channel. Nothing from an earlier channel or an earlier pass carries into a later one.
- R4: With the channel's invert bit at 0, `out_act` is 1 exactly when the sum of the channel's `SIC` slice counts is greater than or equal to its threshold.
- R5: With the channel's invert bit at 1, `out_act` is 1 exactly when the sum is strictly less than the threshold.
- R6: `out_valid` is high for one cycle per output channel, three clock edges after the edge that samples that channel's last slice. `out_ch` carries the channel index, and indices run 0 to `SOC-1` and then wrap to 0.
- R7: A cycle with `in_valid` low advances no slice or channel counter and changes no sum. Gaps between slices do not alter any result.
- R8: When `thr_we` is high at a clock edge, `thr_value` and `thr_invert` are stored as the entry for channel `thr_addr`. Results for that channel use the stored entry afterwards.
- R9: Sums reach the full range 0 to `PIC*SIC` without wrapping. A sum exactly equal to the threshold counts as reaching it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Activation and weight words are present this cycle |
| in_act | input | PIC | Binary input activations, one bit per input channel |
| in_wgt | input | PIC | Binary weights matching `in_act` bit for bit |
| thr_we | input | 1 | Threshold buffer write enable |
| thr_addr | input | CH_W | Output channel whose threshold entry is written |
| thr_value | input | ACC_W | Unsigned integer threshold to store |
| thr_invert | input | 1 | Invert bit to store with the threshold |
| out_valid | output | 1 | One-cycle pulse: an output activation is ready |
| out_act | output | 1 | One-bit output activation |
| out_ch | output | CH_W | Output channel index of `out_act` |

## Verification
The bench builds the element with `PIC=64`, `SIC=3` and `SOC=4`. With two 32-bit words per input, the adder tree must join word counts, and the full-scale sum of 192 can be reached and compared against an equal threshold. Four channels let the channel index wrap several times within a short run, so clearing between passes and rewrites of single buffer entries can be seen. A behavioural model built on queues and integers predicts the valid, activation and channel outputs on every clock. The stimulus includes exact boundary sums, inverted channels, idle gaps between slices and long random runs.

// File: rtl/bnn_pe_pkg.sv
package bnn_pe_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned WCNT_W = $clog2(WORD_W + 1);

    // Position of a word within its output channel's slice sequence
    typedef struct packed {
        logic first;
        logic last;
    } slice_pos_t;

    // Ones count of one 32-bit agreement word
    function automatic logic [WCNT_W-1:0] pop_word(input logic [WORD_W-1:0] w);
        logic [WCNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            s = s + WCNT_W'(w[i]);
        end
        return s;
    endfunction

endpackage

// File: rtl/bnn_pop_tree.sv
module bnn_pop_tree
    import bnn_pe_pkg::*;
#(
    parameter int unsigned PIC   = 64,
    parameter int unsigned SUM_W = 7,
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [PIC-1:0]   act,
    input  logic [PIC-1:0]   wgt,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [SUM_W-1:0] out_sum
);
    localparam int unsigned NWORD = PIC / WORD_W;

    logic [PIC-1:0]    agree;
    logic [WCNT_W-1:0] wcnt_q [NWORD];
    logic              v1_q;
    logic [TAG_W-1:0]  tag1_q;
    logic [SUM_W-1:0]  word_sum;

    assign agree = ~(act ^ wgt);

    // Stage 1: one registered count per 32-bit word
    for (genvar g = 0; g < int'(NWORD); g++) begin : g_word
        always_ff @(posedge clk) begin
            wcnt_q[g] <= pop_word(agree[g*WORD_W +: WORD_W]);
        end
    end

    always_comb begin
        word_sum = '0;
        for (int i = 0; i < int'(NWORD); i++) begin
            word_sum = word_sum + SUM_W'(wcnt_q[i]);
        end
    end

    // Stage 2: joined word counts; valid and tag travel alongside
    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1_q      <= in_valid;
            out_valid <= v1_q;
        end
        tag1_q  <= in_tag;
        out_tag <= tag1_q;
        out_sum <= word_sum;
    end

    assert_tree_bound_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sum <= SUM_W'(PIC)));

    assert_tree_delay_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

endmodule

// File: rtl/bnn_thr_buf.sv
module bnn_thr_buf #(
    parameter int unsigned SOC   = 4,
    parameter int unsigned CH_W  = 2,
    parameter int unsigned TH_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_addr,
    input  logic [TH_W-1:0] wr_value,
    input  logic            wr_invert,
    input  logic [CH_W-1:0] rd_addr,
    output logic [TH_W-1:0] rd_value,
    output logic            rd_invert
);
    logic [TH_W-1:0] value_q  [SOC];
    logic            invert_q [SOC];

    for (genvar e = 0; e < int'(SOC); e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                value_q[e]  <= '0;
                invert_q[e] <= 1'b0;
            end else if (wr_en && wr_addr == CH_W'(e)) begin
                value_q[e]  <= wr_value;
                invert_q[e] <= wr_invert;
            end
        end
    end

    assign rd_value  = value_q[rd_addr];
    assign rd_invert = invert_q[rd_addr];

    assert_thr_addr_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({1'b0, wr_addr} < (CH_W+1)'(SOC)));

endmodule

// File: rtl/bnn_acc_cmp.sv
module bnn_acc_cmp
    import bnn_pe_pkg::*;
#(
    parameter int unsigned SUM_W   = 7,
    parameter int unsigned ACC_W   = 8,
    parameter int unsigned CH_W    = 2,
    parameter int unsigned ACC_MAX = 192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  slice_pos_t       in_pos,
    input  logic [CH_W-1:0]  in_ch,
    input  logic [SUM_W-1:0] in_sum,
    input  logic [ACC_W-1:0] thr_value,
    input  logic             thr_invert,
    output logic             out_valid,
    output logic             out_act,
    output logic [CH_W-1:0]  out_ch
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] total;
    logic             reached;

    assign total   = in_pos.first ? ACC_W'(in_sum) : acc_q + ACC_W'(in_sum);
    assign reached = (total >= thr_value);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_act   <= 1'b0;
            out_ch    <= '0;
        end else begin
            out_valid <= in_valid && in_pos.last;
            if (in_valid) begin
                acc_q <= total;
            end
            if (in_valid && in_pos.last) begin
                out_act <= reached ^ thr_invert;
                out_ch  <= in_ch;
            end
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        acc_q <= ACC_W'(ACC_MAX));

    assert_pulse_source_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_pos.last));

endmodule

// File: rtl/bnn_xnor_pe.sv
module bnn_xnor_pe
    import bnn_pe_pkg::*;
#(
    parameter int unsigned PIC   = 64,
    parameter int unsigned SIC   = 3,
    parameter int unsigned SOC   = 4,
    parameter int unsigned CH_W  = (SOC > 1) ? $clog2(SOC) : 1,
    parameter int unsigned ACC_W = $clog2(PIC * SIC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIC-1:0]   in_act,
    input  logic [PIC-1:0]   in_wgt,
    input  logic             thr_we,
    input  logic [CH_W-1:0]  thr_addr,
    input  logic [ACC_W-1:0] thr_value,
    input  logic             thr_invert,
    output logic             out_valid,
    output logic             out_act,
    output logic [CH_W-1:0]  out_ch
);
    localparam int unsigned SL_W  = (SIC > 1) ? $clog2(SIC) : 1;
    localparam int unsigned SUM_W = $clog2(PIC + 1);
    localparam int unsigned TAG_W = CH_W + $bits(slice_pos_t);

    logic [SL_W-1:0]  slice_q;
    logic [CH_W-1:0]  ch_q;
    slice_pos_t       pos_now;
    logic             t_valid;
    logic [TAG_W-1:0] t_tag;
    logic [SUM_W-1:0] t_sum;
    slice_pos_t       t_pos;
    logic [CH_W-1:0]  t_ch;
    logic [ACC_W-1:0] th_value;
    logic             th_invert;

    assign pos_now.first = (slice_q == '0);
    assign pos_now.last  = (slice_q == SL_W'(SIC - 1));

    // Slice and output-channel sequencing on accepted words
    always_ff @(posedge clk) begin
        if (rst) begin
            slice_q <= '0;
            ch_q    <= '0;
        end else if (in_valid) begin
            if (pos_now.last) begin
                slice_q <= '0;
                ch_q    <= (ch_q == CH_W'(SOC - 1)) ? '0 : ch_q + 1'b1;
            end else begin
                slice_q <= slice_q + 1'b1;
            end
        end
    end

    bnn_pop_tree #(.PIC(PIC), .SUM_W(SUM_W), .TAG_W(TAG_W)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_tag   ({ch_q, pos_now}),
        .act      (in_act),
        .wgt      (in_wgt),
        .out_valid(t_valid),
        .out_tag  (t_tag),
        .out_sum  (t_sum)
    );

    assign {t_ch, t_pos} = t_tag;

    bnn_thr_buf #(.SOC(SOC), .CH_W(CH_W), .TH_W(ACC_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (thr_we),
        .wr_addr  (thr_addr),
        .wr_value (thr_value),
        .wr_invert(thr_invert),
        .rd_addr  (t_ch),
        .rd_value (th_value),
        .rd_invert(th_invert)
    );

    bnn_acc_cmp #(.SUM_W(SUM_W), .ACC_W(ACC_W), .CH_W(CH_W), .ACC_MAX(PIC * SIC)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (t_valid),
        .in_pos    (t_pos),
        .in_ch     (t_ch),
        .in_sum    (t_sum),
        .thr_value (th_value),
        .thr_invert(th_invert),
        .out_valid (out_valid),
        .out_act   (out_act),
        .out_ch    (out_ch)
    );

    assert_slice_range_R3: assert property (@(posedge clk) disable iff (rst)
        slice_q <= SL_W'(SIC - 1));

    assert_out_ch_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({1'b0, out_ch} < (CH_W+1)'(SOC)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(slice_q) && $stable(ch_q)));

endmodule

// File: tb/sim_bnn_xnor_pe.sv
module sim_bnn_xnor_pe;
    localparam int PIC   = 64;
    localparam int SIC   = 3;
    localparam int SOC   = 4;
    localparam int CH_W  = $clog2(SOC);
    localparam int ACC_W = $clog2(PIC * SIC + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [PIC-1:0]   in_act, in_wgt;
    logic             thr_we;
    logic [CH_W-1:0]  thr_addr;
    logic [ACC_W-1:0] thr_value;
    logic             thr_invert;
    logic             out_valid, out_act;
    logic [CH_W-1:0]  out_ch;

    always #10 clk = ~clk;

    bnn_xnor_pe #(.PIC(PIC), .SIC(SIC), .SOC(SOC)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act), .in_wgt(in_wgt),
        .thr_we(thr_we), .thr_addr(thr_addr), .thr_value(thr_value), .thr_invert(thr_invert),
        .out_valid(out_valid), .out_act(out_act), .out_ch(out_ch)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Behavioural reference state
    int    m_th   [SOC];
    bit    m_inv  [SOC];
    int    m_slice = 0;
    int    m_ch    = 0;
    int    m_acc   = 0;
    bit    d_v   [3];
    bit    d_a   [3];
    int    d_c   [3];
    string d_tag [3];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: compare outputs with the model, then drive the next inputs
    task automatic step(bit v, logic [PIC-1:0] a, logic [PIC-1:0] w,
                        bit we, int addr, int val, bit inv, string tag);
        bit nv, na;
        int nc;
        @(negedge clk);
        check(d_tag[2], "out_valid", 32'(out_valid), 32'(d_v[2]));
        if (d_v[2] && out_valid) begin
            check(d_tag[2], "out_act", 32'(out_act), 32'(d_a[2]));
            check(d_tag[2], "out_ch", 32'(out_ch), 32'(d_c[2]));
        end
        nv = 0; na = 0; nc = 0;
        if (v) begin
            int cnt = $countones(~(a ^ w));
            m_acc = (m_slice == 0) ? cnt : m_acc + cnt;
            if (m_slice == SIC - 1) begin
                nv = 1;
                na = m_inv[m_ch] ? (m_acc < m_th[m_ch]) : (m_acc >= m_th[m_ch]);
                nc = m_ch;
                m_slice = 0;
                m_ch = (m_ch == SOC - 1) ? 0 : m_ch + 1;
            end else begin
                m_slice++;
            end
        end
        if (we) begin
            m_th[addr]  = val;
            m_inv[addr] = inv;
        end
        for (int i = 2; i > 0; i--) begin
            d_v[i] = d_v[i-1]; d_a[i] = d_a[i-1]; d_c[i] = d_c[i-1]; d_tag[i] = d_tag[i-1];
        end
        d_v[0] = nv; d_a[0] = na; d_c[0] = nc; d_tag[0] = tag;
        in_valid   = v;
        in_act     = a;
        in_wgt     = w;
        thr_we     = we;
        thr_addr   = CH_W'(addr);
        thr_value  = ACC_W'(val);
        thr_invert = inv;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr_thr(int addr, int val, bit inv);
        step(0, '0, '0, 1, addr, val, inv, "R8");
    endtask

    // Word pair with exactly n agreeing bit positions
    function automatic logic [PIC-1:0] agree_n(int n);
        return {PIC{1'b1}} << n;
    endfunction

    task automatic slice_n(int n, string tag);
        step(1, agree_n(n), '0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin d_v[i] = 0; d_a[i] = 0; d_c[i] = 0; d_tag[i] = "R1"; end
        for (int i = 0; i < SOC; i++) begin m_th[i] = 0; m_inv[i] = 0; end
        rst = 1; in_valid = 0; in_act = '0; in_wgt = '0;
        thr_we = 0; thr_addr = '0; thr_value = '0; thr_invert = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "out_valid after reset", 32'(out_valid), 0);
        check("R1", "out_act after reset", 32'(out_act), 0);
        check("R1", "out_ch after reset", 32'(out_ch), 0);

        // R8: load thresholds
        wr_thr(0, PIC * SIC, 0);
        wr_thr(1, 97, 0);
        wr_thr(2, 50, 1);
        wr_thr(3, 0, 0);

        // R9: full-scale sum equal to threshold gives 1
        slice_n(PIC, "R9"); slice_n(PIC, "R9"); slice_n(PIC, "R9");
        // R4: sum 96 one below threshold 97 gives 0, with gaps (R7)
        slice_n(32, "R4"); idle(2, "R7"); slice_n(32, "R7"); idle(1, "R7"); slice_n(32, "R4");
        // R5: inverted channel, sum 50 equal to threshold gives 0
        slice_n(20, "R5"); slice_n(20, "R5"); slice_n(10, "R5");
        // R3: zero sum against zero threshold gives 1, wrap to channel 0 follows
        slice_n(0, "R3"); slice_n(0, "R3"); slice_n(0, "R3");
        idle(4, "R6");

        // R8: rewrite entries, then a second pass shows clearing (R3)
        wr_thr(1, 96, 1);
        wr_thr(2, 49, 1);
        wr_thr(0, 1, 0);
        slice_n(0, "R3"); slice_n(1, "R3"); slice_n(0, "R3");
        slice_n(31, "R5"); slice_n(32, "R5"); slice_n(32, "R5");
        slice_n(16, "R5"); slice_n(16, "R5"); slice_n(16, "R5");
        slice_n(PIC, "R9"); slice_n(0, "R9"); slice_n(0, "R9");
        idle(4, "R6");

        // R2/R6: random words, back-to-back and with gaps, thresholds near the mean
        for (int round = 0; round < 12; round++) begin
            for (int c = 0; c < SOC; c++)
                wr_thr(c, 80 + int'($urandom_range(0, 32)), bit'($urandom_range(0, 1)));
            for (int k = 0; k < SOC * SIC * 5; k++) begin
                if (round > 0 && $urandom_range(0, 3) == 0) idle(1, "R7");
                step(1, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, 0,
                     (round == 0) ? "R6" : "R2");
            end
            idle(4, "R6");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule